// File: doc/BRIEF.md
# NAND Flash Operation Sequencer

This block lets software drive a NAND flash device one bus operation at a time. Software fills small registers with a command byte, an address value, a chip selection and a configuration word. It then writes a one-hot trigger into the operation register. The sequencer produces the strobes for that single operation: command latch, address latch, write strobe, read strobe and per-chip enables. It also watches the device ready/busy line, so software never has to poll that pin.

The sequencer signals the end of every operation with a sticky completion flag. Software clears the flag by writing it to zero. The flag also drives an interrupt output that software can mask.

Page transfers move a fixed number of bytes. A program transfer puts the byte index on the data bus. A read transfer keeps the last byte sampled, and software can read it back. Timing comes from fixed cycle counts, not from device timing parameters.

A soft-reset bit returns the sequencer to idle. The bit clears itself and reads back as 1 while the reset is in progress. A two-bit configuration field is decoded into the block size in pages.

Top module: `nfs_seq`

## Requirements
- R1: The operation register (address 0) has one-hot trigger bits: bit0 command, bit1 address, bit2 data input, bit3 data output, bit4 ID read, bit5 status read. If several bits are written together, the lowest one wins. A trigger starts only when the sequencer is idle. A command sends the low byte of register 3 as a single write pulse with the command latch high. An address sends the low byte of register 4 as a single write pulse with the address latch high. While an operation runs, bits 5:0 read back its one-hot code; they read 0 when idle.
- R2: Data input gives PAGE_BYTES write pulses with neither latch high, carrying byte index 0, 1, 2 and so on. Completion is not flagged until the ready line (high = ready) is seen high, after a fixed gap.
- R3: Data output waits for the ready line, then gives PAGE_BYTES read pulses. An ID read gives ID_BYTES read pulses and a status read gives one, with no ready wait. The byte sampled on the last read pulse reads back in bits 7:0 of register 5.
- R4: Bit 15 of the operation register is set when an operation completes. It stays set until software writes the operation register with bit 15 = 0. Writing it with bit 15 = 1 leaves it unchanged.
- R5: irq is high exactly when the completion flag is set and configuration (register 1) bit 4 is 0.
- R6: Writing 1 to configuration bit 6 starts a soft reset. Bit 6 reads 1 until the reset ends, at most 8 cycles later. The reset aborts any running operation, returns the sequencer to idle and clears the completion flag.
- R7: nand_ce_n[k] is low only when configuration bit 7 is 1 and bits 6:5 of the buffer register (register 2) equal k. Otherwise it is high.
- R8: Bits 2:0 of the buffer register are cleared to 0 when a data input, data output, ID read or status read starts. A command or address operation leaves them unchanged.
- R9: A trigger written while an operation is in progress is ignored. It has no effect on the strobes or on the active operation code.
- R10: pages_per_block is 32, 64, 128 or 256 for configuration bits 10:9 = 0, 1, 2 or 3.
- R11: After reset, all registers read 0, all strobes and chip enables are inactive (high), and irq is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 3 | Register address |
| reg_wdata | input | 16 | Register write data |
| reg_rdata | output | 16 | Register read data for reg_addr (combinational) |
| irq | output | 1 | Completion interrupt |
| nand_ce_n | output | 4 | Active-low chip enables, one per device |
| nand_cle | output | 1 | Command latch enable |
| nand_ale | output | 1 | Address latch enable |
| nand_we_n | output | 1 | Active-low write strobe |
| nand_re_n | output | 1 | Active-low read strobe |
| nand_dq_o | output | 8 | Data bus out |
| nand_dq_oe | output | 1 | Data bus output enable |
| nand_dq_i | input | 8 | Data bus in |
| nand_rb_n | input | 1 | Device ready (1) / busy (0) |
| pages_per_block | output | 9 | Decoded block size in pages |

## Verification
The bench builds the block with its default parameters: four-byte pages, a two-byte ID, two-cycle strobe phases, a two-cycle busy gap and a four-cycle soft reset. With pages this short, every byte of a page transfer can be counted and its data checked exactly. The bench flash model returns a byte that increases with each read pulse, so the value read back shows both the pulse count and the sampling point. The short soft reset lets the bench confirm the 8-cycle limit, and a held-busy ready line keeps an operation in progress long enough to test the retrigger and ready-wait rules.

// File: rtl/nfs_pkg.sv
package nfs_pkg;

    localparam int REG_AW = 3;
    localparam int REG_DW = 16;

    localparam logic [REG_AW-1:0] ADR_OP   = 3'd0;
    localparam logic [REG_AW-1:0] ADR_CFG  = 3'd1;
    localparam logic [REG_AW-1:0] ADR_BUF  = 3'd2;
    localparam logic [REG_AW-1:0] ADR_CMD  = 3'd3;
    localparam logic [REG_AW-1:0] ADR_ADDR = 3'd4;
    localparam logic [REG_AW-1:0] ADR_RDAT = 3'd5;

    localparam int NUM_OPS  = 6;
    localparam int OPB_CMD  = 0;
    localparam int OPB_ADDR = 1;
    localparam int OPB_PROG = 2;
    localparam int OPB_READ = 3;
    localparam int OPB_ID   = 4;
    localparam int OPB_STAT = 5;
    localparam int DONE_BIT = 15;

    localparam int CFG_MASK_BIT = 4;
    localparam int CFG_SRST_BIT = 6;
    localparam int CFG_CE_BIT   = 7;
    localparam int CFG_PPB_LO   = 9;

    localparam int CS_W   = 2;
    localparam int CHIPS  = 1 << CS_W;
    localparam int BUF_W  = 3;
    localparam int CS_LO  = 5;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_PRE_RDY,
        ST_XFER,
        ST_GAP,
        ST_POST_RDY
    } seq_st_e;

endpackage

// File: rtl/nfs_rb_sync.sv
module nfs_rb_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic rb_n,
    output logic rdy
);
    logic [STAGES-1:0] sync_d, sync_q;

    always_comb begin
        sync_d = {sync_q[STAGES-2:0], rb_n};
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) sync_q <= '0;
        else        sync_q <= sync_d;
    end

    assign rdy = sync_q[STAGES-1];
endmodule

// File: rtl/nfs_cfg_regs.sv
module nfs_cfg_regs
    import nfs_pkg::*;
#(
    parameter int RST_CYC = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [REG_AW-1:0] wr_addr,
    input  logic [REG_DW-1:0] wr_data,
    input  logic              clr_buf,
    output logic              irq_mask,
    output logic              ce_en,
    output logic [1:0]        ppb_sel,
    output logic              srst_busy,
    output logic [BUF_W-1:0]  buf_sel,
    output logic [CS_W-1:0]   chip_sel,
    output logic [7:0]        cmd_byte,
    output logic [15:0]       addr_word
);
    localparam int RCW = $clog2(RST_CYC + 1);

    typedef struct packed {
        logic             mask;
        logic             ce;
        logic [1:0]       ppb;
        logic [RCW-1:0]   rcnt;
        logic [BUF_W-1:0] bsel;
        logic [CS_W-1:0]  csel;
        logic [7:0]       cmd;
        logic [15:0]      addr;
    } regs_t;

    regs_t r_d, r_q;

    always_comb begin
        r_d = r_q;
        if (r_q.rcnt != '0) r_d.rcnt = r_q.rcnt - 1'b1;
        if (wr_en) begin
            case (wr_addr)
                ADR_CFG: begin
                    r_d.mask = wr_data[CFG_MASK_BIT];
                    r_d.ce   = wr_data[CFG_CE_BIT];
                    r_d.ppb  = wr_data[CFG_PPB_LO +: 2];
                    if (wr_data[CFG_SRST_BIT]) r_d.rcnt = RCW'(RST_CYC);
                end
                ADR_BUF: begin
                    r_d.bsel = wr_data[BUF_W-1:0];
                    r_d.csel = wr_data[CS_LO +: CS_W];
                end
                ADR_CMD:  r_d.cmd  = wr_data[7:0];
                ADR_ADDR: r_d.addr = wr_data;
                default: ;
            endcase
        end
        if (clr_buf) r_d.bsel = '0;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) r_q <= '0;
        else        r_q <= r_d;
    end

    assign irq_mask  = r_q.mask;
    assign ce_en     = r_q.ce;
    assign ppb_sel   = r_q.ppb;
    assign srst_busy = (r_q.rcnt != '0);
    assign buf_sel   = r_q.bsel;
    assign chip_sel  = r_q.csel;
    assign cmd_byte  = r_q.cmd;
    assign addr_word = r_q.addr;

    // R8: a data-phase start leaves the buffer field at zero
    a_r8_buf_cleared: assert property (@(posedge clk) disable iff (!rst_n)
        clr_buf |=> (r_q.bsel == '0));

    // R6: the soft reset count only moves down while no new reset is written
    a_r6_srst_counts_down: assert property (@(posedge clk) disable iff (!rst_n)
        (srst_busy && !(wr_en && wr_addr == ADR_CFG && wr_data[CFG_SRST_BIT]))
        |=> (r_q.rcnt == $past(r_q.rcnt) - 1'b1));
endmodule

// File: rtl/nfs_engine.sv
module nfs_engine
    import nfs_pkg::*;
#(
    parameter int PAGE_BYTES = 4,
    parameter int ID_BYTES   = 2,
    parameter int PULSE_CYC  = 2,
    parameter int GAP_CYC    = 2
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                op_wr,
    input  logic [NUM_OPS-1:0]  op_trig,
    input  logic                op_keep_done,
    input  logic                srst,
    input  logic                rdy,
    input  logic [7:0]          cmd_byte,
    input  logic [7:0]          addr_byte,
    input  logic [7:0]          dq_i,
    output logic [NUM_OPS-1:0]  act,
    output logic                done,
    output logic [7:0]          rdata,
    output logic                start_data,
    output logic                cle,
    output logic                ale,
    output logic                we_n,
    output logic                re_n,
    output logic [7:0]          dq_o,
    output logic                dq_oe
);
    localparam int CMAX = (PULSE_CYC > GAP_CYC) ? PULSE_CYC : GAP_CYC;
    localparam int CW   = $clog2(CMAX + 1);
    localparam int BMAX = (PAGE_BYTES > ID_BYTES) ? PAGE_BYTES : ID_BYTES;
    localparam int BW   = $clog2(BMAX + 1);

    typedef struct packed {
        seq_st_e            st;
        logic [NUM_OPS-1:0] act;
        logic               done;
        logic               phase;
        logic [CW-1:0]      cnt;
        logic [BW-1:0]      idx;
        logic [7:0]         rdata;
    } eng_t;

    eng_t s_d, s_q;
    logic [NUM_OPS-1:0] sel;
    logic [BW-1:0]      last_idx;
    logic               wr_op, rd_op, xfer;

    assign wr_op = s_q.act[OPB_CMD] | s_q.act[OPB_ADDR] | s_q.act[OPB_PROG];
    assign rd_op = s_q.act[OPB_READ] | s_q.act[OPB_ID] | s_q.act[OPB_STAT];
    assign xfer  = (s_q.st == ST_XFER);

    always_comb begin
        if (s_q.act[OPB_PROG] || s_q.act[OPB_READ]) last_idx = BW'(PAGE_BYTES - 1);
        else if (s_q.act[OPB_ID])                   last_idx = BW'(ID_BYTES - 1);
        else                                        last_idx = '0;
    end

    always_comb begin
        s_d        = s_q;
        start_data = 1'b0;
        sel        = op_trig & (~op_trig + 1'b1);
        if (op_wr && !op_keep_done) s_d.done = 1'b0;

        case (s_q.st)
            ST_IDLE: begin
                if (op_wr && (op_trig != '0)) begin
                    s_d.act   = sel;
                    s_d.idx   = '0;
                    s_d.cnt   = '0;
                    s_d.phase = 1'b0;
                    s_d.st    = sel[OPB_READ] ? ST_PRE_RDY : ST_XFER;
                    start_data = sel[OPB_PROG] | sel[OPB_READ] | sel[OPB_ID] | sel[OPB_STAT];
                end
            end
            ST_PRE_RDY: begin
                if (rdy) s_d.st = ST_XFER;
            end
            ST_XFER: begin
                if (s_q.cnt == CW'(PULSE_CYC - 1)) begin
                    s_d.cnt = '0;
                    if (!s_q.phase) begin
                        s_d.phase = 1'b1;
                        if (rd_op) s_d.rdata = dq_i;
                    end else begin
                        s_d.phase = 1'b0;
                        if (s_q.idx == last_idx) begin
                            if (s_q.act[OPB_PROG]) begin
                                s_d.st = ST_GAP;
                            end else begin
                                s_d.st   = ST_IDLE;
                                s_d.act  = '0;
                                s_d.done = 1'b1;
                            end
                        end else begin
                            s_d.idx = s_q.idx + 1'b1;
                        end
                    end
                end else begin
                    s_d.cnt = s_q.cnt + 1'b1;
                end
            end
            ST_GAP: begin
                if (s_q.cnt == CW'(GAP_CYC - 1)) begin
                    s_d.cnt = '0;
                    s_d.st  = ST_POST_RDY;
                end else begin
                    s_d.cnt = s_q.cnt + 1'b1;
                end
            end
            ST_POST_RDY: begin
                if (rdy) begin
                    s_d.st   = ST_IDLE;
                    s_d.act  = '0;
                    s_d.done = 1'b1;
                end
            end
            default: s_d.st = ST_IDLE;
        endcase

        if (srst) begin
            s_d.st    = ST_IDLE;
            s_d.act   = '0;
            s_d.done  = 1'b0;
            s_d.phase = 1'b0;
            s_d.cnt   = '0;
            s_d.idx   = '0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    assign act   = s_q.act;
    assign done  = s_q.done;
    assign rdata = s_q.rdata;
    assign we_n  = !(xfer && wr_op && !s_q.phase);
    assign re_n  = !(xfer && rd_op && !s_q.phase);
    assign cle   = xfer && s_q.act[OPB_CMD];
    assign ale   = xfer && s_q.act[OPB_ADDR];
    assign dq_oe = xfer && wr_op;
    assign dq_o  = s_q.act[OPB_CMD]  ? cmd_byte :
                   s_q.act[OPB_ADDR] ? addr_byte : 8'(s_q.idx);

    // R1: at most one operation is active
    a_r1_onehot_act: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(s_q.act));

    // R9: a running operation keeps its code until it ends
    a_r9_no_retrigger: assert property (@(posedge clk) disable iff (!rst_n)
        (s_q.st != ST_IDLE && !srst) |=> (s_q.act == $past(s_q.act) || s_q.act == '0));

    // R4: the flag only falls on a clearing write or a soft reset
    a_r4_done_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        (s_q.done && !(op_wr && !op_keep_done) && !srst) |=> s_q.done);

    // R2: a program that sees busy stays in its wait
    a_r2_prog_waits_ready: assert property (@(posedge clk) disable iff (!rst_n || srst)
        (s_q.st == ST_POST_RDY && !rdy) |=> (s_q.st == ST_POST_RDY));

    // R3: no read strobe before the device is ready
    a_r3_read_waits_ready: assert property (@(posedge clk) disable iff (!rst_n)
        (s_q.st == ST_PRE_RDY && !rdy) |=> re_n);

    // R1: write and read strobes never overlap
    a_r1_strobe_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
        !(!we_n && !re_n));
endmodule

// File: rtl/nfs_seq.sv
module nfs_seq
    import nfs_pkg::*;
#(
    parameter int PAGE_BYTES = 4,
    parameter int ID_BYTES   = 2,
    parameter int PULSE_CYC  = 2,
    parameter int GAP_CYC    = 2,
    parameter int RST_CYC    = 4,
    parameter int SYNC_STG   = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              reg_we,
    input  logic [REG_AW-1:0] reg_addr,
    input  logic [REG_DW-1:0] reg_wdata,
    output logic [REG_DW-1:0] reg_rdata,
    output logic              irq,
    output logic [CHIPS-1:0]  nand_ce_n,
    output logic              nand_cle,
    output logic              nand_ale,
    output logic              nand_we_n,
    output logic              nand_re_n,
    output logic [7:0]        nand_dq_o,
    output logic              nand_dq_oe,
    input  logic [7:0]        nand_dq_i,
    input  logic              nand_rb_n,
    output logic [8:0]        pages_per_block
);
    logic               irq_mask, ce_en, srst_busy, start_data, rdy, done, op_wr;
    logic [1:0]         ppb_sel;
    logic [BUF_W-1:0]   buf_sel;
    logic [CS_W-1:0]    chip_sel;
    logic [7:0]         cmd_byte, rdata;
    logic [15:0]        addr_word;
    logic [NUM_OPS-1:0] act;

    assign op_wr = reg_we && (reg_addr == ADR_OP);

    nfs_cfg_regs #(.RST_CYC(RST_CYC)) u_regs (
        .clk(clk), .rst_n(rst_n),
        .wr_en(reg_we), .wr_addr(reg_addr), .wr_data(reg_wdata),
        .clr_buf(start_data),
        .irq_mask(irq_mask), .ce_en(ce_en), .ppb_sel(ppb_sel),
        .srst_busy(srst_busy), .buf_sel(buf_sel), .chip_sel(chip_sel),
        .cmd_byte(cmd_byte), .addr_word(addr_word)
    );

    nfs_rb_sync #(.STAGES(SYNC_STG)) u_sync (
        .clk(clk), .rst_n(rst_n), .rb_n(nand_rb_n), .rdy(rdy)
    );

    nfs_engine #(
        .PAGE_BYTES(PAGE_BYTES), .ID_BYTES(ID_BYTES),
        .PULSE_CYC(PULSE_CYC), .GAP_CYC(GAP_CYC)
    ) u_eng (
        .clk(clk), .rst_n(rst_n),
        .op_wr(op_wr), .op_trig(reg_wdata[NUM_OPS-1:0]),
        .op_keep_done(reg_wdata[DONE_BIT]),
        .srst(srst_busy), .rdy(rdy),
        .cmd_byte(cmd_byte), .addr_byte(addr_word[7:0]), .dq_i(nand_dq_i),
        .act(act), .done(done), .rdata(rdata), .start_data(start_data),
        .cle(nand_cle), .ale(nand_ale), .we_n(nand_we_n), .re_n(nand_re_n),
        .dq_o(nand_dq_o), .dq_oe(nand_dq_oe)
    );

    always_comb begin
        case (reg_addr)
            ADR_OP:   reg_rdata = {done, 9'b0, act};
            ADR_CFG:  reg_rdata = {5'b0, ppb_sel, 1'b0, ce_en, srst_busy, 1'b0,
                                   irq_mask, 4'b0};
            ADR_BUF:  reg_rdata = {9'b0, chip_sel, 2'b0, buf_sel};
            ADR_CMD:  reg_rdata = {8'b0, cmd_byte};
            ADR_ADDR: reg_rdata = addr_word;
            ADR_RDAT: reg_rdata = {8'b0, rdata};
            default:  reg_rdata = '0;
        endcase
    end

    assign irq             = done & ~irq_mask;
    assign pages_per_block = 9'd32 << ppb_sel;

    for (genvar k = 0; k < CHIPS; k++) begin : g_ce
        assign nand_ce_n[k] = !(ce_en && (chip_sel == CS_W'(k)));
    end

    // R7: never more than one device enabled
    a_r7_ce_onehot: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(~nand_ce_n));

    // R5: no interrupt without a completed operation
    a_r5_irq_needs_done: assert property (@(posedge clk) disable iff (!rst_n)
        irq |-> done);
endmodule

// File: tb/tb_nfs_seq.sv
`timescale 1ns/1ps
module tb_nfs_seq;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        reg_we = 1'b0;
    logic [2:0]  reg_addr = '0;
    logic [15:0] reg_wdata = '0;
    logic [15:0] reg_rdata;
    logic        irq;
    logic [3:0]  nand_ce_n;
    logic        nand_cle, nand_ale, nand_we_n, nand_re_n, nand_dq_oe;
    logic [7:0]  nand_dq_o, nand_dq_i;
    logic        nand_rb_n = 1'b1;
    logic [8:0]  pages_per_block;

    int total = 0, fails = 0;
    int we_cnt = 0, re_cnt = 0, cle_cnt = 0, ale_cnt = 0, re_base = 0;
    logic [7:0] last_dq = '0;
    logic prev_we = 1'b1, prev_re = 1'b1;

    always #10 clk = ~clk;

    nfs_seq dut (
        .clk(clk), .rst_n(rst_n), .reg_we(reg_we), .reg_addr(reg_addr),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .irq(irq),
        .nand_ce_n(nand_ce_n), .nand_cle(nand_cle), .nand_ale(nand_ale),
        .nand_we_n(nand_we_n), .nand_re_n(nand_re_n), .nand_dq_o(nand_dq_o),
        .nand_dq_oe(nand_dq_oe), .nand_dq_i(nand_dq_i), .nand_rb_n(nand_rb_n),
        .pages_per_block(pages_per_block)
    );

    // flash model: byte returned grows with each read pulse
    assign nand_dq_i = 8'hA0 + 8'(re_cnt - re_base);

    always @(negedge clk) begin
        if (prev_we && !nand_we_n) begin
            we_cnt  <= we_cnt + 1;
            last_dq <= nand_dq_o;
            if (nand_cle) cle_cnt <= cle_cnt + 1;
            if (nand_ale) ale_cnt <= ale_cnt + 1;
        end
        if (prev_re && !nand_re_n) re_cnt <= re_cnt + 1;
        prev_we <= nand_we_n;
        prev_re <= nand_re_n;
    end

    task automatic chk(input logic ok, input string what, input int act_v, input int exp_v);
        total++;
        if (!ok) begin
            fails++;
            $display("FAIL %s: actual 0x%0h expected 0x%0h", what, act_v, exp_v);
        end
    endtask

    task automatic wr(input logic [2:0] a, input logic [15:0] d);
        @(negedge clk);
        reg_we = 1'b1; reg_addr = a; reg_wdata = d;
        @(negedge clk);
        reg_we = 1'b0;
    endtask

    task automatic rd(input logic [2:0] a, output logic [15:0] d);
        @(negedge clk);
        reg_addr = a;
        #1 d = reg_rdata;
    endtask

    task automatic wait_done(output logic ok);
        logic [15:0] v;
        ok = 1'b0;
        for (int i = 0; i < 400; i++) begin
            rd(3'd0, v);
            if (v[15]) begin ok = 1'b1; break; end
        end
    endtask

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    typedef struct packed {
        logic [15:0] trig;
        logic [7:0]  cmd;
        logic [15:0] addr;
        logic [7:0]  n_we;
        logic [7:0]  n_re;
        logic [7:0]  dq;
        logic [7:0]  n_cle;
        logic [7:0]  n_ale;
        logic [7:0]  rdat;
    } vec_t;

    // R1 command/address/priority, R2 program, R3 reads
    localparam vec_t VEC [7] = '{
        '{16'h0001, 8'h5A, 16'h0000, 8'd1, 8'd0, 8'h5A, 8'd1, 8'd0, 8'h00},
        '{16'h0002, 8'h00, 16'h1234, 8'd1, 8'd0, 8'h34, 8'd0, 8'd1, 8'h00},
        '{16'h0004, 8'h00, 16'h0000, 8'd4, 8'd0, 8'h03, 8'd0, 8'd0, 8'h00},
        '{16'h0008, 8'h00, 16'h0000, 8'd0, 8'd4, 8'h00, 8'd0, 8'd0, 8'hA4},
        '{16'h0010, 8'h00, 16'h0000, 8'd0, 8'd2, 8'h00, 8'd0, 8'd0, 8'hA2},
        '{16'h0020, 8'h00, 16'h0000, 8'd0, 8'd1, 8'h00, 8'd0, 8'd0, 8'hA1},
        '{16'h0006, 8'h00, 16'h0077, 8'd1, 8'd0, 8'h77, 8'd0, 8'd1, 8'h00}
    };

    initial begin
        #(20 * 150000);
        total++; fails++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("%0d/%0d checks passed", total - fails, total);
        $finish;
    end

    initial begin
        logic [15:0] v;
        logic ok;
        int b_we, b_re, b_cle, b_ale, n;

        idle(3);
        rst_n = 1'b1;
        idle(2);

        // R11 reset state
        for (int a = 0; a < 6; a++) begin
            rd(3'(a), v);
            chk(v == 16'h0, "R11 register reset value", v, 0);
        end
        chk(nand_we_n && nand_re_n && !nand_cle && !nand_ale, "R11 strobes idle",
            {nand_we_n, nand_re_n, nand_cle, nand_ale}, 4'b1100);
        chk(nand_ce_n == 4'hF && !irq, "R11 ce/irq idle", {nand_ce_n, irq}, 5'b11110);

        // vector loop: R1 R2 R3
        foreach (VEC[i]) begin
            wr(3'd3, {8'h00, VEC[i].cmd});
            wr(3'd4, VEC[i].addr);
            idle(1);
            b_we = we_cnt; b_re = re_cnt; b_cle = cle_cnt; b_ale = ale_cnt; re_base = re_cnt;
            wr(3'd0, VEC[i].trig);
            wait_done(ok);
            idle(2);
            chk(ok, "R1/R2/R3 completion flag", ok, 1);
            chk(we_cnt - b_we == int'(VEC[i].n_we), "R1/R2 write pulse count",
                we_cnt - b_we, VEC[i].n_we);
            chk(re_cnt - b_re == int'(VEC[i].n_re), "R3 read pulse count",
                re_cnt - b_re, VEC[i].n_re);
            chk(cle_cnt - b_cle == int'(VEC[i].n_cle), "R1 command latch pulses",
                cle_cnt - b_cle, VEC[i].n_cle);
            chk(ale_cnt - b_ale == int'(VEC[i].n_ale), "R1 address latch pulses",
                ale_cnt - b_ale, VEC[i].n_ale);
            if (VEC[i].n_we != 0)
                chk(last_dq == VEC[i].dq, "R1/R2 last data byte", last_dq, VEC[i].dq);
            if (VEC[i].n_re != 0) begin
                rd(3'd5, v);
                chk(v[7:0] == VEC[i].rdat, "R3 captured read byte", v[7:0], VEC[i].rdat);
            end
            rd(3'd0, v);
            chk(v[5:0] == 6'h0, "R1 idle after completion", v[5:0], 0);
            wr(3'd0, 16'h0000);
        end

        // R4 sticky flag, R5 irq masking
        wr(3'd3, 16'h00C3);
        wr(3'd0, 16'h0001);
        wait_done(ok);
        idle(10);
        rd(3'd0, v);
        chk(v[15], "R4 flag stays set", v[15], 1);
        chk(irq, "R5 irq with mask clear", irq, 1);
        wr(3'd1, 16'h0010);
        idle(1);
        chk(!irq, "R5 irq masked", irq, 0);
        wr(3'd0, 16'h8000);
        rd(3'd0, v);
        chk(v[15], "R4 write with bit15=1 keeps flag", v[15], 1);
        wr(3'd0, 16'h0000);
        rd(3'd0, v);
        chk(!v[15], "R4 write with bit15=0 clears flag", v[15], 0);
        wr(3'd1, 16'h0000);

        // R2 ready wait and R9 ignored retrigger
        nand_rb_n = 1'b0;
        idle(4);
        b_we = we_cnt; b_cle = cle_cnt;
        wr(3'd0, 16'h0004);
        idle(40);
        rd(3'd0, v);
        chk(v == 16'h0004, "R2 no completion while busy", v, 16'h0004);
        wr(3'd0, 16'h0001);
        idle(3);
        rd(3'd0, v);
        chk(v == 16'h0004, "R9 retrigger ignored, op code kept", v, 16'h0004);
        nand_rb_n = 1'b1;
        wait_done(ok);
        idle(4);
        chk(ok, "R2 completes after ready", ok, 1);
        chk(we_cnt - b_we == 4 && cle_cnt == b_cle, "R9 no extra strobes",
            we_cnt - b_we, 4);
        wr(3'd0, 16'h0000);

        // R3 read waits for ready
        nand_rb_n = 1'b0;
        idle(4);
        b_re = re_cnt; re_base = re_cnt;
        wr(3'd0, 16'h0008);
        idle(20);
        chk(re_cnt == b_re, "R3 no read pulse while busy", re_cnt - b_re, 0);
        nand_rb_n = 1'b1;
        wait_done(ok);
        idle(2);
        chk(ok && re_cnt - b_re == 4, "R3 read after ready", re_cnt - b_re, 4);
        wr(3'd0, 16'h0000);

        // R6 soft reset aborts a waiting read
        nand_rb_n = 1'b0;
        idle(4);
        b_re = re_cnt;
        wr(3'd0, 16'h0008);
        wr(3'd1, 16'h0040);
        rd(3'd1, v);
        chk(v[6], "R6 reset bit reads 1 while active", v[6], 1);
        n = 0;
        while (v[6] && n < 20) begin rd(3'd1, v); n++; end
        chk(n <= 8, "R6 reset ends within 8 cycles", n, 8);
        rd(3'd0, v);
        chk(v == 16'h0000, "R6 sequencer idle, flag clear", v, 0);
        nand_rb_n = 1'b1;
        idle(20);
        chk(re_cnt == b_re, "R6 aborted read issues no pulses", re_cnt - b_re, 0);

        // R7 chip enables
        wr(3'd2, 16'h0040);
        idle(1);
        chk(nand_ce_n == 4'hF, "R7 enables off when ce bit clear", nand_ce_n, 4'hF);
        wr(3'd1, 16'h0080);
        idle(1);
        chk(nand_ce_n == 4'b1011, "R7 chip 2 enabled", nand_ce_n, 4'b1011);
        wr(3'd2, 16'h0060);
        idle(1);
        chk(nand_ce_n == 4'b0111, "R7 chip 3 enabled", nand_ce_n, 4'b0111);

        // R8 buffer field clearing
        wr(3'd2, 16'h0063);
        wr(3'd0, 16'h0001);
        wait_done(ok);
        rd(3'd2, v);
        chk(v == 16'h0063, "R8 command keeps buffer field", v, 16'h0063);
        wr(3'd0, 16'h0000);
        wr(3'd2, 16'h0065);
        wr(3'd0, 16'h0020);
        wait_done(ok);
        rd(3'd2, v);
        chk(v == 16'h0060, "R8 status read clears buffer field", v, 16'h0060);
        wr(3'd0, 16'h0000);

        // R10 pages per block
        for (int p = 0; p < 4; p++) begin
            wr(3'd1, 16'(p << 9));
            idle(1);
            chk(pages_per_block == 9'(32 << p), "R10 pages per block decode",
                pages_per_block, 32 << p);
        end

        $display("%0d/%0d checks passed", total - fails, total);
        $finish;
    end
endmodule